// File: doc/BRIEF.md
# Sound Coprocessor Interval Timer Bank

This block holds three programmable interval timers for a sound coprocessor. A base tick enable, `tick_en`, paces them. The fastest timer advances one stage count on every base tick. The other two share a divide-by-8 prescaler and advance once every eighth base tick. Each timer compares its stage counter against an 8-bit target. When the stage counter reaches the target, it returns to zero and a 4-bit output counter moves up by one.

Software reaches the block through a small write port and a small read port. The write port carries the control byte and the three target bytes. The read port fetches an output counter and clears it in the same cycle. Besides the timer enables, the control byte carries two strobes that clear the host-to-coprocessor port latches, one strobe for each pair of latches. It also carries a flag that maps the boot ROM over the top of the address space. The block registers these three and drives them out to the neighbouring logic.

Top module: `snd_interval_timers`

## Requirements
- R1: After reset, `rom_visible` is 1, both port-clear strobes are 0, every target is 0 and every output counter reads 0.
- R2: Timer 2 advances its stage counter on every cycle in which `tick_en` is 1 and it is enabled. With target T, its output counter rises once every T ticks.
- R3: Timers 0 and 1 advance only on every eighth `tick_en` pulse. A single 3-bit prescaler, free running from reset and common to both, sets that pace.
- R4: A target of 0 gives a period of 256 stage counts.
- R5: The output counter is 4 bits wide and wraps from 15 to 0.
- R6: A control write (`wr_sel`=0) that takes bit i (i=0,1,2) from 0 to 1 clears the stage and output counters of timer i. Writing a 1 to a bit that is already 1 clears nothing.
- R7: A target write (`wr_sel`=1,2,3 for timers 0,1,2) takes effect on the next step, whether or not the timer is enabled. A stage counter at or above the new target wraps on its next step and increments the output counter.
- R8: A control write with bit 4 set pulses `port01_clr` for exactly one cycle, on the cycle after the write. Bit 5 does the same for `port23_clr`.
- R9: `rom_visible` takes the value of bit 7 of the last control write, one cycle after that write.
- R10: A read (`rd_en`, `rd_sel`=0..2) returns the output counter on `rd_data`, with `rd_valid` high on the next cycle, and clears the counter. If an increment lands in the same cycle as the read, the counter becomes 1. A `rd_sel` of 3 returns 0.
- R11: While a timer is disabled, its stage and output counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base timer tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 selects control, 1 to 3 select the target of timer 0 to 2 |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Output-counter read strobe |
| rd_sel | input | 2 | Timer whose output counter is read |
| rd_data | output | 4 | Read data, registered |
| rd_valid | output | 1 | High on the cycle after a read |
| port01_clr | output | 1 | One-cycle clear strobe for port latches 0 and 1 |
| port23_clr | output | 1 | One-cycle clear strobe for port latches 2 and 3 |
| rom_visible | output | 1 | Boot ROM mapped over the top of the address space |

## Verification
The hardest state to reach from the ports is a slow timer with a target of 0 or 255. Moving its output counter even twice takes more than four thousand base ticks, and the prescaler's phase at the moment the timer is enabled shifts every expected count. Directed runs hold `tick_en` high for long stretches and take the starting phase from the bench's own tick count since reset. A random phase then mixes in target rewrites below a running stage count, re-enables, and reads that land on an increment.

// File: rtl/snd_tmr_pkg.sv
package snd_tmr_pkg;
  localparam int TMR_N      = 3;
  localparam int TGT_W      = 8;
  localparam int CNT_W      = 4;
  localparam int PRE_W      = 3;
  localparam int DATA_W     = 8;
  localparam int CB_CLR_LO  = 4;
  localparam int CB_CLR_HI  = 5;
  localparam int CB_ROM     = 7;
  localparam logic [DATA_W-1:0] CTRL_RESET = 8'h80;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TGT0 = 2'd1,
    SEL_TGT1 = 2'd2,
    SEL_TGT2 = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/snd_tmr_prescale.sv
module snd_tmr_prescale #(
  parameter int PRE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic slow_tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (tick_en) pre_q <= pre_q + 1'b1;
  end

  // fires on the tick that wraps the prescaler
  assign slow_tick = tick_en & (&pre_q);
endmodule

// File: rtl/snd_tmr_ctrl.sv
module snd_tmr_ctrl #(
  parameter int TMR_N     = 3,
  parameter int DATA_W    = 8,
  parameter int CB_CLR_LO = 4,
  parameter int CB_CLR_HI = 5,
  parameter int CB_ROM    = 7,
  parameter logic [DATA_W-1:0] CTRL_RESET = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TMR_N-1:0]  en_q,
  output logic [TMR_N-1:0]  en_rise,
  output logic              port01_clr,
  output logic              port23_clr,
  output logic              rom_visible
);
  logic [TMR_N-1:0] en_nxt;
  logic             unused_ctrl_bits;

  assign en_nxt  = wr_data[TMR_N-1:0];
  assign en_rise = {TMR_N{wr_ctrl}} & en_nxt & ~en_q;
  assign unused_ctrl_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= CTRL_RESET[TMR_N-1:0];
      rom_visible <= CTRL_RESET[CB_ROM];
      port01_clr  <= 1'b0;
      port23_clr  <= 1'b0;
    end else begin
      port01_clr <= wr_ctrl & wr_data[CB_CLR_LO];
      port23_clr <= wr_ctrl & wr_data[CB_CLR_HI];
      if (wr_ctrl) begin
        en_q        <= en_nxt;
        rom_visible <= wr_data[CB_ROM];
      end
    end
  end
endmodule

// File: rtl/snd_tmr_chan.sv
module snd_tmr_chan #(
  parameter int TGT_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             en,
  input  logic             restart,
  input  logic             tgt_wr,
  input  logic [TGT_W-1:0] tgt_data,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [TGT_W:0] FULL_PERIOD = {1'b1, {TGT_W{1'b0}}};

  logic [TGT_W-1:0] tgt_q;
  logic [TGT_W-1:0] stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TGT_W:0]   period;
  logic [TGT_W:0]   stage_inc;
  logic             adv;
  logic             wrap;

  assign period    = (tgt_q == '0) ? FULL_PERIOD : {1'b0, tgt_q};
  assign stage_inc = {1'b0, stage_q} + 1'b1;
  assign adv       = step & en;
  assign wrap      = adv & (stage_inc >= period);
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q   <= '0;
      stage_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (tgt_wr) tgt_q <= tgt_data;
      if (restart) begin
        stage_q <= '0;
        cnt_q   <= '0;
      end else begin
        if (adv) stage_q <= wrap ? '0 : stage_inc[TGT_W-1:0];
        if (rd_clr)     cnt_q <= wrap ? CNT_W'(1) : '0;
        else if (wrap)  cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/snd_interval_timers.sv
module snd_interval_timers
  import snd_tmr_pkg::*;
#(
  parameter int TMR_NUM = TMR_N,
  parameter int T_W     = TGT_W,
  parameter int C_W     = CNT_W,
  parameter int P_W     = PRE_W,
  parameter int D_W     = DATA_W,
  parameter int SEL_W   = $clog2(TMR_NUM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [D_W-1:0]   wr_data,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [C_W-1:0]   rd_data,
  output logic             rd_valid,
  output logic             port01_clr,
  output logic             port23_clr,
  output logic             rom_visible
);
  localparam int FAST_IDX = TMR_NUM - 1;

  logic                     slow_tick;
  logic                     wr_ctrl;
  logic [TMR_NUM-1:0]       en_q;
  logic [TMR_NUM-1:0]       en_rise;
  logic [TMR_NUM*C_W-1:0]   cnt_flat;
  logic [C_W-1:0]           rd_mux;

  assign wr_ctrl = wr_en & (wr_sel == SEL_W'(0));

  snd_tmr_prescale #(.PRE_W(P_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .slow_tick (slow_tick)
  );

  snd_tmr_ctrl #(
    .TMR_N     (TMR_NUM),
    .DATA_W    (D_W),
    .CB_CLR_LO (CB_CLR_LO),
    .CB_CLR_HI (CB_CLR_HI),
    .CB_ROM    (CB_ROM),
    .CTRL_RESET(CTRL_RESET)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_ctrl     (wr_ctrl),
    .wr_data     (wr_data),
    .en_q        (en_q),
    .en_rise     (en_rise),
    .port01_clr  (port01_clr),
    .port23_clr  (port23_clr),
    .rom_visible (rom_visible)
  );

  for (genvar gi = 0; gi < TMR_NUM; gi++) begin : g_chan
    logic step_i;
    if (gi == FAST_IDX) begin : g_fast
      assign step_i = tick_en;
    end else begin : g_slow
      assign step_i = slow_tick;
    end

    snd_tmr_chan #(.TGT_W(T_W), .CNT_W(C_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .step     (step_i),
      .en       (en_q[gi]),
      .restart  (en_rise[gi]),
      .tgt_wr   (wr_en & (wr_sel == SEL_W'(gi + 1))),
      .tgt_data (wr_data[T_W-1:0]),
      .rd_clr   (rd_en & (rd_sel == SEL_W'(gi))),
      .cnt      (cnt_flat[gi*C_W +: C_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < TMR_NUM; i++) begin
      if (rd_sel == SEL_W'(i)) rd_mux = cnt_flat[i*C_W +: C_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/snd_interval_timers_chk.sv
module snd_interval_timers_chk #(
  parameter int TMR_NUM = 3,
  parameter int C_W     = 4,
  parameter int D_W     = 8,
  parameter int SEL_W   = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [SEL_W-1:0]       wr_sel,
  input logic [D_W-1:0]         wr_data,
  input logic                   rd_en,
  input logic [SEL_W-1:0]       rd_sel,
  input logic                   rd_valid,
  input logic                   port01_clr,
  input logic                   port23_clr,
  input logic                   rom_visible,
  input logic [TMR_NUM-1:0]     en_q,
  input logic [TMR_NUM*C_W-1:0] cnt_flat
);
  logic wr_c;
  assign wr_c = wr_en && (wr_sel == SEL_W'(0));

  AST_RESET_ROM: assert property (@(posedge clk) rst |=> rom_visible); // R1
  AST_CLR01_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_c && wr_data[4]) |=> port01_clr); // R8
  AST_CLR01_ONLY: assert property (@(posedge clk) disable iff (rst)
    port01_clr |-> $past(wr_c && wr_data[4])); // R8
  AST_CLR23_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_c && wr_data[5]) |=> port23_clr); // R8
  AST_ROM_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    wr_c |=> (rom_visible == $past(wr_data[7]))); // R9
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R10

  for (genvar gi = 0; gi < TMR_NUM; gi++) begin : g_chk
    AST_RISE_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (wr_c && wr_data[gi] && !en_q[gi]) |=> (cnt_flat[gi*C_W +: C_W] == '0)); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!en_q[gi] && !wr_c && !(rd_en && rd_sel == SEL_W'(gi)))
        |=> $stable(cnt_flat[gi*C_W +: C_W])); // R11
  end
endmodule

bind snd_interval_timers snd_interval_timers_chk #(
  .TMR_NUM(TMR_NUM), .C_W(C_W), .D_W(D_W), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_sel     (rd_sel),
  .rd_valid   (rd_valid),
  .port01_clr (port01_clr),
  .port23_clr (port23_clr),
  .rom_visible(rom_visible),
  .en_q       (en_q),
  .cnt_flat   (cnt_flat)
);

// File: tb/snd_interval_timers_bench.sv
module snd_interval_timers_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [3:0] rd_data;
  logic       rd_valid;
  logic       port01_clr;
  logic       port23_clr;
  logic       rom_visible;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference state
  int  m_pre = 0;
  int  m_tgt[3];
  int  m_stage[3];
  int  m_cnt[3];
  bit  m_en[3];
  bit  m_rom = 1;
  int  exp_rd;
  bit  exp_c01, exp_c23;
  int  last_rd;

  always #5 clk = ~clk;

  snd_interval_timers u_snd_interval_timers (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .rd_valid(rd_valid), .port01_clr(port01_clr), .port23_clr(port23_clr),
    .rom_visible(rom_visible)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int per_of(int t);
    return (t == 0) ? 256 : t;
  endfunction

  // one clock: drive at negedge, update the model at the edge, compare at next negedge
  task automatic cyc(bit tk, bit wr, logic [1:0] ws, logic [7:0] wd, bit rd, logic [1:0] rs);
    bit slow;
    bit inc[3];
    tick_en = tk; wr_en = wr; wr_sel = ws; wr_data = wd; rd_en = rd; rd_sel = rs;
    @(posedge clk);
    slow = tk && (m_pre == 7);
    if (tk) m_pre = (m_pre + 1) % 8;
    exp_rd = 0;
    for (int i = 0; i < 3; i++) begin
      bit st;
      inc[i] = 0;
      st = m_en[i] && ((i == 2) ? tk : slow);
      if (st) begin
        if (m_stage[i] + 1 >= per_of(m_tgt[i])) begin m_stage[i] = 0; inc[i] = 1; end
        else m_stage[i] = m_stage[i] + 1;
      end
      if (rd && rs == 2'(i)) begin
        exp_rd = m_cnt[i];
        m_cnt[i] = inc[i] ? 1 : 0;
      end else if (inc[i]) m_cnt[i] = (m_cnt[i] + 1) % 16;
      if (wr && ws == 2'd0 && wd[i] && !m_en[i]) begin m_stage[i] = 0; m_cnt[i] = 0; end
    end
    exp_c01 = wr && ws == 2'd0 && wd[4];
    exp_c23 = wr && ws == 2'd0 && wd[5];
    if (wr && ws == 2'd0) begin
      for (int i = 0; i < 3; i++) m_en[i] = wd[i];
      m_rom = wd[7];
    end
    if (wr && ws != 2'd0) m_tgt[int'(ws) - 1] = int'(wd);
    @(negedge clk);
    tick_en = 0; wr_en = 0; rd_en = 0;
    if (rd) begin
      last_rd = int'(rd_data);
      check(rd_valid === 1'b1 && int'(rd_data) == exp_rd, "R10 read value", int'(rd_data), exp_rd);
    end
    if (wr && ws == 2'd0) begin
      check(port01_clr == exp_c01, "R8 port01_clr", int'(port01_clr), int'(exp_c01));
      check(port23_clr == exp_c23, "R8 port23_clr", int'(port23_clr), int'(exp_c23));
      check(rom_visible == m_rom, "R9 rom_visible", int'(rom_visible), int'(m_rom));
    end else if (port01_clr || port23_clr) begin
      check(0, "R8 stray clear strobe", 1, 0);
    end
  endtask

  task automatic idle(int n, bit tk);
    for (int k = 0; k < n; k++) cyc(tk, 0, 2'd0, 8'd0, 0, 2'd0);
  endtask

  task automatic rd_tmr(int idx);
    cyc(0, 0, 2'd0, 8'd0, 1, 2'(idx));
  endtask

  // closed-form increment-rate check
  task automatic rate_test(int idx, int tgt, int nticks, string req);
    int p, steps, exp;
    cyc(0, 1, 2'(idx + 1), 8'(tgt), 0, 2'd0);
    cyc(0, 1, 2'd0, 8'h00, 0, 2'd0);
    cyc(0, 1, 2'd0, 8'(1 << idx), 0, 2'd0);
    p = m_pre;
    idle(nticks, 1);
    steps = (idx == 2) ? nticks : (p + nticks) / 8;
    exp = (steps / per_of(tgt)) % 16;
    rd_tmr(idx);
    check(last_rd == exp, req, last_rd, exp);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin m_tgt[i] = 0; m_stage[i] = 0; m_cnt[i] = 0; m_en[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check(rom_visible == 1'b1, "R1 rom_visible after reset", int'(rom_visible), 1);
    check(!port01_clr && !port23_clr, "R1 clear strobes after reset", int'({port01_clr, port23_clr}), 0);
    for (int i = 0; i < 3; i++) begin
      rd_tmr(i);
      check(last_rd == 0, "R1 counter after reset", last_rd, 0);
    end
    rd_tmr(3);
    check(last_rd == 0, "R10 unused select reads 0", last_rd, 0);

    // R2 / R3 / R4 rates for targets 0, 1, 255
    rate_test(2, 1,   37,   "R2 fast timer target 1");
    rate_test(2, 255, 800,  "R2 fast timer target 255");
    rate_test(2, 0,   800,  "R4 fast timer target 0");
    rate_test(0, 1,   101,  "R3 slow timer0 target 1");
    rate_test(1, 1,   93,   "R3 slow timer1 target 1");
    rate_test(0, 255, 4200, "R3 slow timer0 target 255");
    rate_test(1, 0,   4200, "R4 slow timer1 target 0");

    // R5 wrap modulo 16
    rate_test(2, 1, 18, "R5 output counter wraps");

    // R6 re-writing an enable bit that is already set does not clear
    cyc(0, 1, 2'd3, 8'd1, 0, 2'd0);
    cyc(0, 1, 2'd0, 8'h00, 0, 2'd0);
    cyc(0, 1, 2'd0, 8'h04, 0, 2'd0);
    idle(5, 1);
    cyc(0, 1, 2'd0, 8'h04, 0, 2'd0);
    rd_tmr(2);
    check(last_rd == 5, "R6 no clear without rising enable", last_rd, 5);
    idle(3, 1);
    cyc(0, 1, 2'd0, 8'h00, 0, 2'd0);
    cyc(0, 1, 2'd0, 8'h04, 0, 2'd0);
    rd_tmr(2);
    check(last_rd == 0, "R6 rising enable clears counter", last_rd, 0);

    // R10 read coinciding with an increment leaves 1
    idle(2, 1);
    cyc(1, 0, 2'd0, 8'd0, 1, 2'd2);
    check(last_rd == 2, "R10 read value before clear", last_rd, 2);
    rd_tmr(2);
    check(last_rd == 1, "R10 coincident increment leaves 1", last_rd, 1);

    // R11 disabled timer frozen
    idle(3, 1);
    cyc(0, 1, 2'd0, 8'h00, 0, 2'd0);
    idle(20, 1);
    rd_tmr(2);
    check(last_rd == 3, "R11 disabled timer holds count", last_rd, 3);

    // R7 target lowered below running stage wraps on next step
    cyc(0, 1, 2'd3, 8'd200, 0, 2'd0);
    cyc(0, 1, 2'd0, 8'h04, 0, 2'd0);
    idle(50, 1);
    cyc(0, 1, 2'd3, 8'd10, 0, 2'd0);
    idle(1, 1);
    rd_tmr(2);
    check(last_rd == 1, "R7 lowered target wraps at once", last_rd, 1);
    idle(9, 1);
    rd_tmr(2);
    check(last_rd == 0, "R7 new period of 10 in use", last_rd, 0);
    idle(1, 1);
    rd_tmr(2);
    check(last_rd == 1, "R7 new period of 10 completes", last_rd, 1);

    // R8 / R9 directed control writes
    cyc(0, 1, 2'd0, 8'h10, 0, 2'd0);
    check(rom_visible == 1'b0, "R9 rom hidden", int'(rom_visible), 0);
    cyc(0, 1, 2'd0, 8'hA0, 0, 2'd0);
    idle(1, 0);
    check(!port23_clr, "R8 strobe lasts one cycle", int'(port23_clr), 0);

    // random phase against the reference
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 6000; k++) begin
      int r;
      bit tk, wr, rd;
      logic [1:0] ws, rs;
      logic [7:0] wd;
      r  = $urandom_range(0, 99);
      tk = ($urandom_range(0, 3) != 0);
      wr = (r < 6);
      rd = (r >= 6 && r < 26);
      ws = 2'($urandom_range(0, 3));
      wd = 8'($urandom_range(0, 255));
      if (ws != 2'd0 && $urandom_range(0, 3) == 0) wd = 8'($urandom_range(0, 3));
      if (ws == 2'd0) wd[2:0] = wd[2:0] | 3'($urandom_range(0, 7));
      rs = 2'($urandom_range(0, 3));
      cyc(tk, wr, ws, wd, rd, rs);
    end
    for (int i = 0; i < 3; i++) rd_tmr(i);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule